// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects interrupt requests and decides which one the processor should service next. There are up to sixteen maskable request lines, plus two request lines that cannot be masked: a reset-class line and a fault-class line. A pulse on any request line marks that source as pending. A maskable source can only compete when its own enable bit is set and the global enable input is high. Each maskable line has a programmable three-bit priority. The two unmaskable sources have fixed levels above every maskable one.

When a source wins, the block raises a one-cycle take strobe and puts the winner's exception number on the output. The winner then becomes the running exception on a small stack of active priorities. A later request is taken only if it is strictly more urgent than the running one. A return pulse pops the stack, which lets pending work of lower urgency proceed. Software programs enables and priorities through a small write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A maskable line is taken only while its enable bit is set and `global_en` is high.
- R2: A write with `wr_sel`=0 sets the enable of every line whose `wr_data` bit is 1. A write with `wr_sel`=1 clears those enables. A write with `wr_sel`=2 loads `wr_data[2:0]` as the priority of line `wr_idx`. A write with `wr_sel`=3 does nothing.
- R3: The reset-class and fault-class requests are taken regardless of all enables, including `global_en`.
- R4: Urgency follows a level, where a lower level wins. The reset-class source has level 0 (priority -3). The fault-class source has level 2 (priority -1). Maskable line i has level prio_i+3. When two levels are equal, the lower exception number wins.
- R5: A pending request preempts the running exception only when its level is strictly lower. Otherwise it stays pending and is taken after the return pulse.
- R6: Exception numbers are 1 for the reset-class source, 3 for the fault-class source, and 16+i for maskable line i.
- R7: A request pulse latches a pending bit. The bit survives while the source is disabled and is cleared when the source is taken.
- R8: A request pulse sampled at clock edge k gives `take_o` high for exactly one cycle after edge k+1. The taken source shows up in `act_depth_o`/`act_lvl_o` after edge k+2.
- R9: The active stack holds 4 levels. A return pulse restores the previous running level. While the stack is full, no further take happens.
- R10: After reset, `take_o` is 0, `act_depth_o` is 0 and `act_lvl_o` is all ones (idle). All enables and priorities are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_LINES | Maskable request pulses |
| rst_req | input | 1 | Reset-class request pulse |
| fault_req | input | 1 | Fault-class request pulse |
| global_en | input | 1 | Global enable for maskable lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write kind: 0 set-enable, 1 clear-enable, 2 priority, 3 none |
| wr_idx | input | $clog2(N_LINES) | Line index for priority writes |
| wr_data | input | N_LINES | Enable mask or priority value |
| ret_pulse | input | 1 | Return-from-handler pulse |
| take_o | output | 1 | One-cycle take strobe |
| exc_num_o | output | $clog2(N_LINES+16) | Exception number of the taken source |
| act_depth_o | output | $clog2(STACK_DEPTH+1) | Number of running exceptions |
| act_lvl_o | output | PRIO_W+1 | Level of the innermost running exception |

## Verification
The hardest state to reach is a full active stack with an urgent fault request waiting behind it. To get there, the bench gives four lines strictly rising urgency and takes them one after another. It then raises a fault request and confirms that the fault is held off. After a single return pulse, the fault must preempt the entry that is now on top, and later returns must peel the levels back in order. Equal-priority ties and lines that are disabled but still pending are driven in the same scoreboarded run. Each expected exception number is queued before its stimulus is applied.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   typedef enum logic [1:0] {
      WR_SETEN = 2'd0,
      WR_CLREN = 2'd1,
      WR_PRIO  = 2'd2,
      WR_NONE  = 2'd3
   } wr_kind_e;

   // slot order inside the controller: 0 reset-class, 1 fault-class, 2.. lines
   localparam int SLOT_RST   = 0;
   localparam int SLOT_FLT   = 1;
   localparam int SLOT_LINE0 = 2;

   localparam int EXC_RST    = 1;
   localparam int EXC_FLT    = 3;
   localparam int EXC_BASE   = 16;

   localparam int LVL_RST    = 0;
   localparam int LVL_FLT    = 2;
   localparam int LVL_OFS    = 3;

   function automatic int slot_to_exc(input int slot);
      if (slot == SLOT_RST)      return EXC_RST;
      else if (slot == SLOT_FLT) return EXC_FLT;
      else                       return EXC_BASE + slot - SLOT_LINE0;
   endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
   import prio_irq_pkg::*;
#(
   parameter int N_LINES = 16,
   parameter int PRIO_W  = 3,
   localparam int IDX_W  = $clog2(N_LINES),
   localparam int N_SLOT = N_LINES + 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_LINES-1:0]         irq_req,
   input  logic                       rst_req,
   input  logic                       fault_req,
   input  logic                       global_en,
   input  logic                       wr_en,
   input  wr_kind_e                   wr_kind,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [N_LINES-1:0]         wr_data,
   input  logic [N_SLOT-1:0]          clr_vec,
   output logic [N_SLOT-1:0]          elig_o,
   output logic [N_SLOT-1:0]          pend_o,
   output logic [N_LINES*PRIO_W-1:0]  prio_flat_o
);

   logic [N_SLOT-1:0]        pend_q;
   logic [N_LINES-1:0]       en_q;
   logic [PRIO_W-1:0]        prio_q [N_LINES];
   logic [N_SLOT-1:0]        set_vec;

   assign set_vec = {irq_req, fault_req, rst_req};

   // a fresh pulse wins over a same-cycle clear so no request is lost
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_en) begin
         case (wr_kind)
            WR_SETEN: en_q <= en_q | wr_data;
            WR_CLREN: en_q <= en_q & ~wr_data;
            default:  en_q <= en_q;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_prio
         always_ff @(posedge clk) begin
            if (!rst_n)
               prio_q[g] <= '0;
            else if (wr_en && wr_kind == WR_PRIO && wr_idx == IDX_W'(g))
               prio_q[g] <= wr_data[PRIO_W-1:0];
         end
         assign prio_flat_o[g*PRIO_W +: PRIO_W] = prio_q[g];
      end
   endgenerate

   assign elig_o[SLOT_RST] = pend_q[SLOT_RST];
   assign elig_o[SLOT_FLT] = pend_q[SLOT_FLT];
   assign elig_o[N_SLOT-1:SLOT_LINE0] =
      pend_q[N_SLOT-1:SLOT_LINE0] & en_q & {N_LINES{global_en}};
   assign pend_o = pend_q;

   // R7: a taken slot drops its pending bit unless re-requested
   a_r7_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[SLOT_FLT] && !fault_req) |=> !pend_q[SLOT_FLT]);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import prio_irq_pkg::*;
#(
   parameter int N_LINES  = 16,
   parameter int PRIO_W   = 3,
   localparam int N_SLOT  = N_LINES + 2,
   localparam int SLOT_W  = $clog2(N_SLOT),
   localparam int LVL_W   = $clog2((1 << PRIO_W) + LVL_OFS)
) (
   input  logic [N_SLOT-1:0]          elig,
   input  logic [N_LINES*PRIO_W-1:0]  prio_flat,
   output logic                       sel_ok_o,
   output logic [SLOT_W-1:0]          sel_slot_o,
   output logic [LVL_W-1:0]           sel_lvl_o
);

   logic [LVL_W-1:0] lvl [N_SLOT];

   assign lvl[SLOT_RST] = LVL_W'(LVL_RST);
   assign lvl[SLOT_FLT] = LVL_W'(LVL_FLT);

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_lvl
         assign lvl[SLOT_LINE0+g] =
            LVL_W'(prio_flat[g*PRIO_W +: PRIO_W]) + LVL_W'(LVL_OFS);
      end
   endgenerate

   // slots scanned in exception-number order; strict compare keeps the
   // earlier (lower-numbered) slot on equal levels
   always_comb begin
      sel_ok_o   = 1'b0;
      sel_slot_o = '0;
      sel_lvl_o  = '1;
      for (int s = 0; s < N_SLOT; s++) begin
         if (elig[s] && (!sel_ok_o || lvl[s] < sel_lvl_o)) begin
            sel_ok_o   = 1'b1;
            sel_slot_o = SLOT_W'(s);
            sel_lvl_o  = lvl[s];
         end
      end
   end

endmodule

// File: rtl/irq_act_stack.sv
module irq_act_stack #(
   parameter int DEPTH  = 4,
   parameter int LVL_W  = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [LVL_W-1:0] push_lvl,
   input  logic             pop,
   output logic [CNT_W-1:0] depth_o,
   output logic [LVL_W-1:0] top_lvl_o,
   output logic             full_o
);

   logic [LVL_W-1:0] stk_q [DEPTH];
   logic [CNT_W-1:0] cnt_q;
   logic [LVL_W-1:0] below_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (push && pop) begin
         stk_q[cnt_q-1'b1] <= push_lvl;
      end else if (push) begin
         stk_q[cnt_q] <= push_lvl;
         cnt_q        <= cnt_q + 1'b1;
      end else if (pop) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign depth_o   = cnt_q;
   assign full_o    = (cnt_q == CNT_W'(DEPTH));
   assign top_lvl_o = (cnt_q == '0) ? '1 : stk_q[cnt_q-1'b1];
   assign below_lvl = (cnt_q < CNT_W'(2)) ? '1 : stk_q[cnt_q-CNT_W'(2)];

   // R9: never push past capacity, and a return uncovers the entry below
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> !full_o);
   a_r9_pop_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> top_lvl_o == $past(below_lvl));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int N_LINES     = 16,
   parameter int PRIO_W      = 3,
   parameter int STACK_DEPTH = 4,
   localparam int IDX_W  = $clog2(N_LINES),
   localparam int EXC_W  = $clog2(N_LINES + EXC_BASE),
   localparam int CNT_W  = $clog2(STACK_DEPTH + 1),
   localparam int LVL_W  = $clog2((1 << PRIO_W) + LVL_OFS),
   localparam int N_SLOT = N_LINES + 2,
   localparam int SLOT_W = $clog2(N_SLOT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_req,
   input  logic               rst_req,
   input  logic               fault_req,
   input  logic               global_en,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [N_LINES-1:0] wr_data,
   input  logic               ret_pulse,
   output logic               take_o,
   output logic [EXC_W-1:0]   exc_num_o,
   output logic [CNT_W-1:0]   act_depth_o,
   output logic [LVL_W-1:0]   act_lvl_o
);

   if (N_LINES < 2 || N_LINES > 16) begin : g_chk_lines
      $error("N_LINES must lie in 2..16");
   end
   if (N_LINES < PRIO_W) begin : g_chk_data
      $error("wr_data too narrow for a priority field");
   end
   if (STACK_DEPTH < 1) begin : g_chk_depth
      $error("STACK_DEPTH must be at least 1");
   end

   logic [N_SLOT-1:0]         elig, pend, clr_vec;
   logic [N_LINES*PRIO_W-1:0] prio_flat;
   logic                      sel_ok, stk_full, take_now, pop;
   logic [SLOT_W-1:0]         sel_slot;
   logic [LVL_W-1:0]          sel_lvl, take_lvl_q;
   logic                      take_q;
   logic [EXC_W-1:0]          exc_q;

   irq_pend_bank #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_bank (
      .clk, .rst_n, .irq_req, .rst_req, .fault_req, .global_en, .wr_en,
      .wr_kind(wr_kind_e'(wr_sel)), .wr_idx, .wr_data, .clr_vec,
      .elig_o(elig), .pend_o(pend), .prio_flat_o(prio_flat)
   );

   irq_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_arb (
      .elig, .prio_flat,
      .sel_ok_o(sel_ok), .sel_slot_o(sel_slot), .sel_lvl_o(sel_lvl)
   );

   irq_act_stack #(.DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) u_stk (
      .clk, .rst_n, .push(take_q), .push_lvl(take_lvl_q), .pop,
      .depth_o(act_depth_o), .top_lvl_o(act_lvl_o), .full_o(stk_full)
   );

   // no new take while the previous one is still on its way to the stack
   assign take_now = sel_ok && !take_q && !stk_full &&
                     (act_depth_o == '0 || sel_lvl < act_lvl_o);
   assign pop      = ret_pulse && (act_depth_o != '0);

   always_comb begin
      clr_vec = '0;
      if (take_now) clr_vec[sel_slot] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_q     <= 1'b0;
         exc_q      <= '0;
         take_lvl_q <= '1;
      end else begin
         take_q <= take_now;
         if (take_now) begin
            exc_q      <= EXC_W'(slot_to_exc(int'(sel_slot)));
            take_lvl_q <= sel_lvl;
         end
      end
   end

   assign take_o    = take_q;
   assign exc_num_o = exc_q;

   // R8: single-cycle strobe, entry visible on the stack one cycle later
   a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> !take_o);
   a_r8_active_next: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !ret_pulse) |=> act_depth_o == $past(act_depth_o) + 1'b1);
   // R5: a take never lands on an equal or more urgent running level
   a_r5_strict: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !$past(ret_pulse)) |->
         (act_depth_o == CNT_W'(1) || take_lvl_q < $past(act_lvl_o)));
   // R1: maskable numbers only appear when the global enable was high
   a_r1_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && exc_num_o >= EXC_W'(EXC_BASE)) |-> $past(global_en));
   // R3: unmaskable takes need no enable
   a_r3_nmi_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && exc_num_o == EXC_W'(EXC_RST)) |-> $past(pend[SLOT_RST]));

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

   localparam int N = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_req = '0;
   logic         rst_req = 1'b0, fault_req = 1'b0, global_en = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd3;
   logic [3:0]   wr_idx = '0;
   logic [N-1:0] wr_data = '0;
   logic         ret_pulse = 1'b0;
   logic         take_o;
   logic [4:0]   exc_num_o;
   logic [2:0]   act_depth_o;
   logic [3:0]   act_lvl_o;

   int n_chk = 0, n_bad = 0;
   int exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk, .rst_n, .irq_req, .rst_req, .fault_req, .global_en, .wr_en,
      .wr_sel, .wr_idx, .wr_data, .ret_pulse, .take_o, .exc_num_o,
      .act_depth_o, .act_lvl_o
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_take(input int exc, input string tag);
      exp_q.push_back(exc);
      tag_q.push_back(tag);
   endtask

   task automatic wr(input logic [1:0] sel, input int idx, input logic [N-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_idx = 4'(idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3;
   endtask

   task automatic pulse_lines(input logic [N-1:0] m);
      @(negedge clk); irq_req = m;
      @(negedge clk); irq_req = '0;
   endtask

   task automatic pulse_fault();
      @(negedge clk); fault_req = 1'b1;
      @(negedge clk); fault_req = 1'b0;
   endtask

   task automatic pulse_rst();
      @(negedge clk); rst_req = 1'b1;
      @(negedge clk); rst_req = 1'b0;
   endtask

   task automatic ret();
      @(negedge clk); ret_pulse = 1'b1;
      @(negedge clk); ret_pulse = 1'b0;
   endtask

   // monitor: every strobe must match the head of the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && take_o) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R5 unexpected take actual=%0d expected=none", exc_num_o);
         end else begin
            check(tag_q.pop_front(), int'(exc_num_o), exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      check("R10 take after reset", take_o, 0);
      check("R10 depth after reset", act_depth_o, 0);
      check("R10 level after reset", act_lvl_o, 15);

      // R2 enable/priority writes, R6 numbering, R8 timing
      global_en = 1'b1;
      wr(2'd0, 0, 16'h00A0);          // lines 5 and 7
      wr(2'd2, 5, 16'd4);
      wr(2'd2, 7, 16'd4);
      expect_take(21, "R6 line5 number");
      pulse_lines(16'h0020);
      tick(1);
      check("R8 strobe timing", take_o, 1);
      tick(1);
      check("R8 single cycle strobe", take_o, 0);
      check("R8 active depth", act_depth_o, 1);
      check("R4 line level prio+3", act_lvl_o, 7);

      // R5 equal level stays pending until return
      pulse_lines(16'h0080);
      tick(6);
      check("R5 equal held depth", act_depth_o, 1);
      expect_take(23, "R5 taken after return");
      ret();
      tick(4);
      check("R5 depth after return and take", act_depth_o, 1);
      ret();
      tick(2);
      check("R9 empty after return", act_depth_o, 0);

      // R4 tie on equal priority: lower number first
      wr(2'd0, 0, 16'h0208);          // lines 3 and 9
      wr(2'd2, 3, 16'd2);
      wr(2'd2, 9, 16'd2);
      expect_take(19, "R4 tie lower number");
      pulse_lines(16'h0208);
      tick(6);
      expect_take(25, "R4 tie second");
      ret();
      tick(4);
      ret();
      tick(2);

      // R1 global mask, R7 pending kept
      global_en = 1'b0;
      pulse_lines(16'h0008);
      tick(6);
      check("R1 global off no take", act_depth_o, 0);
      expect_take(19, "R7 kept while masked");
      global_en = 1'b1;
      tick(4);
      ret();
      tick(2);
      wr(2'd1, 0, 16'h0008);          // clear-enable line 3
      pulse_lines(16'h0008);
      tick(6);
      check("R2 clear-enable blocks", act_depth_o, 0);
      wr(2'd3, 0, 16'h0008);          // no-op write kind
      tick(4);
      check("R2 write kind 3 ignored", act_depth_o, 0);
      expect_take(19, "R7 pending survives disable");
      wr(2'd0, 0, 16'h0008);
      tick(4);
      ret();
      tick(2);

      // R3 unmaskable sources, R4 reset above fault
      global_en = 1'b0;
      expect_take(3, "R3 fault ignores enables");
      pulse_fault();
      tick(3);
      check("R4 fault level", act_lvl_o, 2);
      expect_take(1, "R3 reset-class preempts fault");
      pulse_rst();
      tick(3);
      check("R4 reset level", act_lvl_o, 0);
      check("R5 nested depth", act_depth_o, 2);
      ret();
      ret();
      tick(2);
      check("R9 back to idle", act_lvl_o, 15);

      // R9 full stack holds off preemption
      global_en = 1'b1;
      wr(2'd0, 0, 16'h000F);
      for (int k = 0; k < 4; k++) wr(2'd2, k, 16'(6 - k));
      for (int k = 0; k < 4; k++) begin
         expect_take(16 + k, "R5 deeper nesting");
         pulse_lines(16'(1 << k));
         tick(3);
      end
      check("R9 stack full depth", act_depth_o, 4);
      check("R9 top level", act_lvl_o, 6);
      pulse_fault();
      tick(6);
      check("R9 full holds fault", act_depth_o, 4);
      expect_take(3, "R9 fault after one return");
      ret();
      tick(4);
      check("R9 refilled depth", act_depth_o, 4);
      check("R9 fault on top", act_lvl_o, 2);
      ret();
      tick(1);
      check("R9 restores level", act_lvl_o, 7);
      ret();
      tick(1);
      check("R9 restores next", act_lvl_o, 8);
      ret();
      ret();
      tick(2);
      check("R9 empty again", act_depth_o, 0);
      check("scoreboard drained", exp_q.size(), 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule